// File: doc/BRIEF.md
# Transceiver Reset and Start-up Sequencer

This block brings a serial audio transceiver core out of reset in a controlled order. An active-low reset can be asserted at any moment. Its release is synchronised to the falling edge of the master clock, so several devices that share the clock and the reset line leave reset on the same edge. While reset is held, everything is cleared, the option (strap) pins are released to act as inputs, and every output stays muted.

On the first falling edge after the synchronised release, the levels on the strap pins are latched. The pins then turn into outputs, and the control registers become writable. The core stays in low power until software sets the RUN bit. Audio and line-transmit outputs are enabled only after the PLL lock indication has been seen high for a programmable run of consecutive cycles.

Losing lock drops the outputs back into waiting, and clearing RUN returns the core to low power. The latched strap values survive both of these. A fixed identification byte can be read at any time outside reset.

Top module: `rstseq_top`

## Requirements
- R1: While `rstN` is low, `outEnable`=0, `lowPower`=1, `strapOe`=0, `strapOut`=0 and `regRdData`=0; this takes effect at once, without waiting for a clock edge.
- R2: After `rstN` rises, two falling edges of `mclk` pass through the synchroniser, and `strapOe` goes all-ones on the third falling edge.
- R3: Register writes are ignored, and reads return 0, until the sequencer has left reset. Address 0 bit 0 is the RUN bit, which can be read and written; its other bits read 0.
- R4: The third falling edge after release latches `strapIn`. The latched value reads at address 2 in bits [N_STRAP-1:0], and `devAddrBit` always equals latched bit 0.
- R5: Outside reset, `strapOut` follows `pinFuncOut`. The latched strap value changes only on a reset release.
- R6: Address 1 returns {DEV_ID in bits [7:4], REV_ID in bits [3:0]}; writes to it have no effect. Address 3 reads 0.
- R7: With RUN clear, `lowPower`=1 and `outEnable`=0 whatever the level of `pllLock`.
- R8: Once RUN is set, `lowPower`=0. `outEnable` rises only after `pllLock` has been sampled high on LOCK_CYCLES consecutive falling edges while waiting. A low sample restarts the count.
- R9: If `pllLock` is low on a falling edge while outputs are enabled, `outEnable` drops on that edge and a fresh full count is required.
- R10: If RUN reads 0 on a falling edge, the next state is low power (`lowPower`=1, `outEnable`=0). A RUN write takes effect one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all state moves on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on regAddr) |
| pllLock | input | 1 | PLL lock indication |
| strapIn | input | N_STRAP | Levels on the strap pins |
| pinFuncOut | input | N_STRAP | Values the pins carry once they become outputs |
| strapOut | output | N_STRAP | Pin output data |
| strapOe | output | N_STRAP | Pin output enable, one per pin |
| devAddrBit | output | 1 | Control-port address bit taken from strap bit 0 |
| outEnable | output | 1 | Enables audio serial and line-transmit outputs |
| lowPower | output | 1 | Core held in low power |

## Verification
Two events can land on the same falling edge: the lock count completing and a write that clears RUN. The bench provokes this by timing the write to land on exactly the edge where the count finishes. The expected result is one cycle of `outEnable` high, followed by low power, because the state machine acts on the stored RUN value. The bench also provokes lock loss together with a RUN clear, expecting a drop to waiting and then to low power. A behavioural model, advanced on every falling edge, judges each port on every clock.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_RESET    = 2'd0,
    ST_IDLE     = 2'd1,
    ST_WAIT_PLL = 2'd2,
    ST_RUN      = 2'd3
  } seqState_t;

  // Strobes from the sequencer to the register/pin datapath.
  typedef struct packed {
    logic captureStrap;
    logic portEnable;
    logic pinOe;
  } seqStrobe_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_ID    = 2'd1;
  localparam logic [1:0] ADDR_STRAP = 2'd2;

endpackage

// File: rtl/rstseq_ctrl.sv
`timescale 1ns/1ps
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       runBit,
  input  logic       pllLock,
  output logic       rstSyncN,
  output seqStrobe_t strobe,
  output logic       outEnable,
  output logic       lowPower
);

  localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  // Reset release synchroniser, asserted asynchronously
  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(negedge mclk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
  end

  assign rstSyncN = syncQ[SYNC_STAGES-1];

  // Sequencing state machine
  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] lockCnt, cntNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = '0;
    unique case (state)
      ST_RESET: stateNxt = ST_IDLE;
      ST_IDLE:  if (runBit) stateNxt = ST_WAIT_PLL;
      ST_WAIT_PLL: begin
        if (!runBit)                stateNxt = ST_IDLE;
        else if (!pllLock)          cntNxt   = '0;
        else if (lockCnt == CNT_LAST) stateNxt = ST_RUN;
        else                        cntNxt   = lockCnt + CNT_W'(1);
      end
      ST_RUN: begin
        if (!runBit)       stateNxt = ST_IDLE;
        else if (!pllLock) stateNxt = ST_WAIT_PLL;
      end
      default: stateNxt = ST_RESET;
    endcase
  end

  always_ff @(negedge mclk or negedge rstSyncN) begin
    if (!rstSyncN) begin
      state   <= ST_RESET;
      lockCnt <= '0;
    end else begin
      state   <= stateNxt;
      lockCnt <= cntNxt;
    end
  end

  always_comb begin
    strobe.captureStrap = (state == ST_RESET);
    strobe.portEnable   = (state != ST_RESET);
    strobe.pinOe        = (state != ST_RESET);
  end

  assign outEnable = (state == ST_RUN);
  assign lowPower  = (state == ST_RESET) || (state == ST_IDLE);

  // R8: enabling only follows a completed lock run with lock still high
  a_r8_enable_after_count: assert property (@(negedge mclk) disable iff (!rstSyncN)
    $rose(outEnable) |-> ($past(lockCnt) == CNT_LAST) && $past(pllLock));

  // R9: lock loss while enabled drops the outputs
  a_r9_lock_loss_mutes: assert property (@(negedge mclk) disable iff (!rstSyncN)
    (outEnable && !pllLock) |=> !outEnable);

  // R10: a cleared RUN bit leads to low power
  a_r10_run_clear_lowpower: assert property (@(negedge mclk) disable iff (!rstSyncN)
    !runBit |=> (lowPower && !outEnable));

endmodule

// File: rtl/rstseq_dp.sv
`timescale 1ns/1ps
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int         N_STRAP = 3,
  parameter int         DATA_W  = 8,
  parameter int         ADDR_W  = 2,
  parameter logic [3:0] DEV_ID  = 4'hA,
  parameter logic [3:0] REV_ID  = 4'h3
) (
  input  logic              mclk,
  input  logic              rstSyncN,
  input  seqStrobe_t        strobe,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [N_STRAP-1:0] strapIn,
  input  logic [N_STRAP-1:0] pinFuncOut,
  output logic              runBit,
  output logic [DATA_W-1:0] regRdData,
  output logic [N_STRAP-1:0] strapOut,
  output logic [N_STRAP-1:0] strapOe,
  output logic              devAddrBit
);

  localparam int ID_W = DATA_W / 2;

  logic [N_STRAP-1:0] strapQ;
  logic               ctrlWrite;
  logic               unusedWrBits;

  assign ctrlWrite    = strobe.portEnable && regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign unusedWrBits = ^regWrData[DATA_W-1:1];

  // RUN bit
  always_ff @(negedge mclk or negedge rstSyncN) begin
    if (!rstSyncN)      runBit <= 1'b0;
    else if (ctrlWrite) runBit <= regWrData[0];
  end

  // Strap latch: loaded only on the reset-exit edge
  always_ff @(negedge mclk or negedge rstSyncN) begin
    if (!rstSyncN)                strapQ <= '0;
    else if (strobe.captureStrap) strapQ <= strapIn;
  end

  assign devAddrBit = strapQ[0];

  // Pin drivers
  for (genvar p = 0; p < N_STRAP; p++) begin : g_pin
    assign strapOe[p]  = strobe.pinOe;
    assign strapOut[p] = strobe.pinOe & pinFuncOut[p];
  end

  // Readback
  always_comb begin
    regRdData = '0;
    if (strobe.portEnable) begin
      unique case (regAddr)
        ADDR_W'(ADDR_CTRL):  regRdData = DATA_W'(runBit);
        ADDR_W'(ADDR_ID):    regRdData = {ID_W'(DEV_ID), ID_W'(REV_ID)};
        ADDR_W'(ADDR_STRAP): regRdData = DATA_W'(strapQ);
        default:             regRdData = '0;
      endcase
    end
  end

  // R5: strap latch holds except on the capture edge
  a_r5_strap_hold: assert property (@(negedge mclk) disable iff (!rstSyncN)
    !strobe.captureStrap |=> $stable(strapQ));

  // R3: no write lands while the port is closed
  a_r3_no_early_write: assert property (@(negedge mclk) disable iff (!rstSyncN)
    !strobe.portEnable |=> !runBit);

  // R2: pins turn to outputs right after the capture edge
  a_r2_oe_follows_capture: assert property (@(negedge mclk) disable iff (!rstSyncN)
    $rose(strobe.pinOe) |-> $past(strobe.captureStrap));

endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int         N_STRAP     = 3,
  parameter int         LOCK_CYCLES = 1024,
  parameter logic [3:0] DEV_ID      = 4'hA,
  parameter logic [3:0] REV_ID      = 4'h3
) (
  input  logic               mclk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  input  logic               pllLock,
  input  logic [N_STRAP-1:0] strapIn,
  input  logic [N_STRAP-1:0] pinFuncOut,
  output logic [N_STRAP-1:0] strapOut,
  output logic [N_STRAP-1:0] strapOe,
  output logic               devAddrBit,
  output logic               outEnable,
  output logic               lowPower
);

  seqStrobe_t strobe;
  logic       rstSyncN;
  logic       runBit;

  rstseq_ctrl #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .mclk     (mclk),
    .rstN     (rstN),
    .runBit   (runBit),
    .pllLock  (pllLock),
    .rstSyncN (rstSyncN),
    .strobe   (strobe),
    .outEnable(outEnable),
    .lowPower (lowPower)
  );

  rstseq_dp #(
    .N_STRAP(N_STRAP),
    .DATA_W (8),
    .ADDR_W (2),
    .DEV_ID (DEV_ID),
    .REV_ID (REV_ID)
  ) u_dp (
    .mclk      (mclk),
    .rstSyncN  (rstSyncN),
    .strobe    (strobe),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strapIn   (strapIn),
    .pinFuncOut(pinFuncOut),
    .runBit    (runBit),
    .regRdData (regRdData),
    .strapOut  (strapOut),
    .strapOe   (strapOe),
    .devAddrBit(devAddrBit)
  );

endmodule

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;

  localparam int NS   = 3;
  localparam int LOCK = 16;
  localparam logic [7:0] ID_BYTE = 8'hA3;

  logic          mclk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [7:0]    regWrData = 8'd0;
  logic [7:0]    regRdData;
  logic          pllLock = 1'b0;
  logic [NS-1:0] strapIn = '0;
  logic [NS-1:0] pinFuncOut = '0;
  logic [NS-1:0] strapOut, strapOe;
  logic          devAddrBit, outEnable, lowPower;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  rstseq_top #(.N_STRAP(NS), .LOCK_CYCLES(LOCK), .DEV_ID(4'hA), .REV_ID(4'h3)) dut (
    .mclk(mclk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pllLock(pllLock),
    .strapIn(strapIn), .pinFuncOut(pinFuncOut), .strapOut(strapOut),
    .strapOe(strapOe), .devAddrBit(devAddrBit), .outEnable(outEnable),
    .lowPower(lowPower)
  );

  always #2 mclk = ~mclk;

  // Behavioural reference: 0 reset, 1 idle, 2 waiting for lock, 3 running
  int          mState = 0;
  int          mSync = 0;
  int          mCnt = 0;
  logic        mRun = 1'b0;
  logic        oldRun;
  logic [NS-1:0] mStrap = '0;

  always @(negedge mclk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mSync = 0; mCnt = 0; mRun = 1'b0; mStrap = '0;
    end else begin
      if (mState == 0) begin
        if (mSync >= 2) begin
          mStrap = strapIn;
          mState = 1;
        end
      end else begin
        oldRun = mRun;
        if (regWrEn && regAddr == 2'd0) mRun = regWrData[0];
        case (mState)
          1: if (oldRun) mState = 2;
          2: begin
            if (!oldRun) begin mState = 1; mCnt = 0; end
            else if (!pllLock) mCnt = 0;
            else if (mCnt == LOCK - 1) begin mState = 3; mCnt = 0; end
            else mCnt = mCnt + 1;
          end
          3: if (!oldRun) mState = 1; else if (!pllLock) mState = 2;
          default: mState = 0;
        endcase
      end
      if (mSync < 2) mSync = mSync + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expRd();
    if (mState == 0) return 8'd0;
    case (regAddr)
      2'd0: return {7'd0, mRun};
      2'd1: return ID_BYTE;
      2'd2: return {{(8-NS){1'b0}}, mStrap};
      default: return 8'd0;
    endcase
  endfunction

  // Every-clock comparison against the model
  always @(posedge mclk) begin
    if (cmpOn && !done) begin
      chk("R8", "outEnable", {31'd0, outEnable}, {31'd0, mState == 3});
      chk("R7", "lowPower", {31'd0, lowPower}, {31'd0, (mState == 0) || (mState == 1)});
      chk("R2", "strapOe", 32'(strapOe), (mState != 0) ? 32'(3'b111) : 32'd0);
      chk("R5", "strapOut", 32'(strapOut), (mState != 0) ? 32'(pinFuncOut) : 32'd0);
      chk("R4", "devAddrBit", {31'd0, devAddrBit}, {31'd0, mStrap[0]});
      chk("R3", "regRdData", 32'(regRdData), 32'(expRd()));
    end
  end

  task automatic step();
    @(posedge mclk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    strapIn = 3'b101; pinFuncOut = 3'b110;
    repeat (3) step();
    cmpOn = 1'b1;
    // R1 reset state
    chk("R1", "outEnable in reset", {31'd0, outEnable}, 32'd0);
    chk("R1", "lowPower in reset", {31'd0, lowPower}, 32'd1);
    chk("R1", "strapOe in reset", 32'(strapOe), 32'd0);
    chk("R1", "strapOut in reset", 32'(strapOut), 32'd0);

    // R3 write held across release is ignored; R2 release timing
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h01;
    rstN = 1'b1;
    step(); chk("R2", "oe after first edge", 32'(strapOe), 32'd0);
    step(); chk("R2", "oe after second edge", 32'(strapOe), 32'd0);
    step(); chk("R2", "oe after third edge", 32'(strapOe), 32'(3'b111));
    chk("R5", "pin data driven", 32'(strapOut), 32'(3'b110));
    regWrEn = 1'b0;
    strapIn = 3'b010;
    #0.5;
    chk("R3", "RUN after early write", 32'(regRdData), 32'd0);
    step();
    regAddr = 2'd2; #0.5;
    chk("R4", "strap readback", 32'(regRdData), 32'd5);
    chk("R4", "address bit", {31'd0, devAddrBit}, 32'd1);

    // R6 identification is read-only
    regAddr = 2'd1; #0.5;
    chk("R6", "id byte", 32'(regRdData), 32'(ID_BYTE));
    wr(2'd1, 8'h00);
    regAddr = 2'd1; #0.5;
    chk("R6", "id after write", 32'(regRdData), 32'(ID_BYTE));
    regAddr = 2'd3; #0.5;
    chk("R6", "unused address", 32'(regRdData), 32'd0);

    // R7 lock alone does not wake the core
    pllLock = 1'b1;
    repeat (LOCK + 4) step();
    chk("R7", "idle with lock", {31'd0, outEnable}, 32'd0);
    chk("R7", "idle low power", {31'd0, lowPower}, 32'd1);

    // R8 lock run with a restart
    pllLock = 1'b0;
    wr(2'd0, 8'h01);
    repeat (5) step();
    chk("R8", "waiting without lock", {31'd0, outEnable}, 32'd0);
    chk("R8", "awake while waiting", {31'd0, lowPower}, 32'd0);
    pllLock = 1'b1;
    repeat (LOCK / 2) step();
    pllLock = 1'b0;
    step();
    pllLock = 1'b1;
    repeat (LOCK - 1) step();
    chk("R8", "one short of count", {31'd0, outEnable}, 32'd0);
    step();
    chk("R8", "count complete", {31'd0, outEnable}, 32'd1);

    // R9 lock loss
    pllLock = 1'b0;
    step();
    chk("R9", "lock lost", {31'd0, outEnable}, 32'd0);
    chk("R9", "still awake", {31'd0, lowPower}, 32'd0);
    pllLock = 1'b1;
    repeat (LOCK - 1) step();
    chk("R9", "recount short", {31'd0, outEnable}, 32'd0);
    step();
    chk("R9", "recount done", {31'd0, outEnable}, 32'd1);

    // R10 RUN clear
    wr(2'd0, 8'h00);
    step();
    chk("R10", "run cleared", {31'd0, outEnable}, 32'd0);
    chk("R10", "back to low power", {31'd0, lowPower}, 32'd1);
    regAddr = 2'd2; #0.5;
    chk("R5", "strap kept", 32'(regRdData), 32'd5);

    // Coincidence: RUN clear lands on the completing edge
    wr(2'd0, 8'h01);
    repeat (LOCK) step();
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h00;
    step();
    regWrEn = 1'b0;
    chk("R8", "enable on completing edge", {31'd0, outEnable}, 32'd1);
    step();
    chk("R10", "stored clear takes effect", {31'd0, outEnable}, 32'd0);
    chk("R10", "low power after clear", {31'd0, lowPower}, 32'd1);

    // Coincidence: lock loss and RUN clear together
    wr(2'd0, 8'h01);
    repeat (LOCK + 2) step();
    chk("R8", "running again", {31'd0, outEnable}, 32'd1);
    pllLock = 1'b0;
    wr(2'd0, 8'h00);
    chk("R9", "loss wins first", {31'd0, lowPower}, 32'd0);
    step();
    chk("R10", "then low power", {31'd0, lowPower}, 32'd1);

    // R1 asynchronous reset while running, then a new strap capture
    pllLock = 1'b1;
    wr(2'd0, 8'h01);
    repeat (LOCK + 2) step();
    rstN = 1'b0;
    #0.5;
    chk("R1", "async mute", {31'd0, outEnable}, 32'd0);
    chk("R1", "async pins input", 32'(strapOe), 32'd0);
    chk("R1", "async read zero", 32'(regRdData), 32'd0);
    strapIn = 3'b011;
    repeat (2) step();
    rstN = 1'b1;
    repeat (3) step();
    regAddr = 2'd2; #0.5;
    chk("R4", "new strap", 32'(regRdData), 32'd3);
    regAddr = 2'd0; #0.5;
    chk("R3", "RUN cleared by reset", 32'(regRdData), 32'd0);
    repeat (3) step();
    finishRun();
  end

endmodule